// File: doc/BRIEF.md
# Calibration Payload Packer

This block reduces each readout chip of an event to one byte and packs those bytes into 64-bit payload words for a detector event builder that runs calibration scans. For each chip, the upstream logic presents the following on one input beat:

- the chip's 5-bit position;
- the two low bits of its event counter;
- its full channel hit map.

The block keeps only the hit bit of one chosen channel. It places the resulting byte into the current word, filling from the top. When the chip flagged as last of its event is accepted, the word in progress is closed with padding ones and emitted. After that, the next event starts on a fresh word.

Alongside the payload, the block produces the fields that a header builder merges in. These are a payload-type and payload-version nibble pair for the event header, the selected channel number for the chamber header, and the count of payload words in the event. A control enable turns the calibration format on or off, and a control input picks the channel. Both are captured on the first accepted chip of an event, so changing them partway through an event cannot corrupt it.

Top module: `calpack_top`

## Requirements
- R1: Each chip becomes one 8-bit record laid out as {hit, ec[1:0], pos[4:0]}. Bit 7 is the chip's hit bit for the selected channel, bits [6:5] are the event counter low bits, and bits [4:0] are the position.
- R2: Records of one event fill a payload word in arrival order. The first record goes to bits [63:56], the next to [55:48], and so on down to [7:0], so one word holds eight records.
- R3: Every record slot that the final word of an event does not use is all ones, so an unused slot decodes as position 31. A word that is not the final one has no padding.
- R4: The word count reported with the end-of-event summary equals the number of payload words emitted for that event, which is ceil(chips/8) and includes the padded word.
- R5: In calibration mode the 11-bit event header field output carries 0xF in bits [7:4] and 0 in bits [10:8]. Its bits [3:0] are always 0.
- R6: In default mode, chips are accepted but no payload word is emitted. The summary then reports word count 0, event header field 0 and channel field 0.
- R7: In calibration mode the summary's channel output equals the channel selected for that event. This 7-bit value is meant for chamber header bits [46:40].
- R8: The mode enable and the channel are sampled when an event's first chip is accepted. Changes to them before that event's last chip is accepted have no effect on its records or summary.
- R9: While out_valid is high and out_ready is low, in_ready is low, and out_word and out_last hold their values.
- R10: In calibration mode, the final word of an event appears with out_last high one cycle after its last chip is accepted. In that same cycle, evt_done pulses for one cycle with the summary outputs updated. In default mode, evt_done pulses one cycle after the last chip is accepted.
- R11: After reset, out_valid, evt_done, the word count, the header field and the channel field are all 0. Each new event's records start in bits [63:56] of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cal_en | input | 1 | Calibration format enable, sampled per event |
| cfg_chan | input | 7 | Channel whose hit bit is kept, sampled per event |
| in_valid | input | 1 | Chip beat valid |
| in_ready | output | 1 | Chip beat accepted when high with in_valid |
| in_last | input | 1 | Beat is the last chip of the event |
| in_pos | input | 5 | Chip position |
| in_ec_lo | input | 2 | Two low bits of the chip event counter |
| in_hits | input | 128 | Chip channel hit map |
| out_valid | output | 1 | Payload word valid |
| out_ready | input | 1 | Downstream accepts payload word |
| out_word | output | 64 | Payload word |
| out_last | output | 1 | Payload word is the final one of its event |
| evt_done | output | 1 | One-cycle pulse: summary outputs updated |
| evt_wcnt | output | 10 | Payload word count of the finished event |
| hdr_evt | output | 11 | Event header field bits [10:0] (type in [7:4], version in [10:8]) |
| hdr_chan | output | 7 | Selected channel for chamber header bits [46:40] |

## Verification
If the slot index goes wrong, records show up in the wrong byte lanes, or a word closes early or late. Both are visible on the next emitted word, no more than eight accepted chips later. If the per-event settings latch goes wrong, a mid-event toggle of the mode or channel flips hit bits or header fields within the same event. If the word counter or the end-of-event reset goes wrong, the summary count is off, or the next event's first record lands in a lower lane; either shows at the next evt_done. Backpressure faults show as a changed out_word during a stall, on the first stalled cycle.

// File: rtl/calpack_pkg.sv
package calpack_pkg;
  localparam int REC_W  = 8;
  localparam int WORD_W = 64;
  localparam int POS_W  = 5;
  localparam int ECL_W  = 2;
  localparam int SLOTS  = WORD_W / REC_W;
  localparam int HDR_W  = 11;

  localparam logic [3:0] PTYPE_CAL = 4'hF;
  localparam logic [2:0] PVER_CAL  = 3'd0;

  typedef struct packed {
    logic             hit;
    logic [ECL_W-1:0] ec_lo;
    logic [POS_W-1:0] pos;
  } rec_t;
endpackage

// File: rtl/cal_rec_build.sv
module cal_rec_build
  import calpack_pkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [ECL_W-1:0]  ec_lo,
  input  logic [NUM_CH-1:0] hits,
  input  logic [CH_W-1:0]   chan,
  output rec_t              rec
);
  always_comb begin
    rec.hit   = hits[chan];
    rec.ec_lo = ec_lo;
    rec.pos   = pos;
  end
endmodule

// File: rtl/cal_evt_ctrl.sv
module cal_evt_ctrl #(
  parameter int CH_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            last,
  input  logic            cfg_en,
  input  logic [CH_W-1:0] cfg_chan,
  output logic            eff_en,
  output logic [CH_W-1:0] eff_chan
);
  logic            evt_open;
  logic            lat_en;
  logic [CH_W-1:0] lat_chan;

  assign eff_en   = evt_open ? lat_en   : cfg_en;
  assign eff_chan = evt_open ? lat_chan : cfg_chan;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_open <= 1'b0;
      lat_en   <= 1'b0;
      lat_chan <= '0;
    end else if (accept) begin
      if (!evt_open) begin
        lat_en   <= cfg_en;
        lat_chan <= cfg_chan;
      end
      evt_open <= !last;
    end
  end

  // R8: settings stay frozen while an event is open
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_open && $past(evt_open)) |-> ($stable(lat_en) && $stable(lat_chan)));
endmodule

// File: rtl/cal_word_pack.sv
module cal_word_pack
  import calpack_pkg::*;
#(
  parameter int WC_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              last,
  input  rec_t              rec,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic [WC_W-1:0]   fin_cnt
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(SLOTS - 1);

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_ins;
  logic [IDX_W-1:0]  idx;
  logic [WC_W-1:0]   wcnt;
  logic              word_done;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int HI = WORD_W - 1 - s * REC_W;
    assign acc_ins[HI -: REC_W] = (idx == IDX_W'(s)) ? rec : acc[HI -: REC_W];
  end

  assign word_done = accept && (last || idx == IDX_MAX);
  assign fin_cnt   = wcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '1;
      idx       <= '0;
      wcnt      <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (accept) begin
        if (word_done) begin
          out_word  <= acc_ins;
          out_valid <= 1'b1;
          out_last  <= last;
          acc       <= '1;
          idx       <= '0;
          wcnt      <= last ? '0 : wcnt + 1'b1;
        end else begin
          acc <= acc_ins;
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R9: a stalled word is held unchanged
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));
  // R9: nothing is accepted into a full output stage
  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !accept);
  // R11: a fresh event starts at the top slot
  assert_slot_reset_R11: assert property (@(posedge clk) disable iff (rst)
    (accept && last) |=> (idx == '0));
endmodule

// File: rtl/calpack_top.sv
module calpack_top
  import calpack_pkg::*;
#(
  parameter int  NUM_CH = 128,
  parameter int  WC_W   = 10,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cal_en,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  input  logic [POS_W-1:0]  in_pos,
  input  logic [ECL_W-1:0]  in_ec_lo,
  input  logic [NUM_CH-1:0] in_hits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic              evt_done,
  output logic [WC_W-1:0]   evt_wcnt,
  output logic [HDR_W-1:0]  hdr_evt,
  output logic [CH_W-1:0]   hdr_chan
);
  logic            accept;
  logic            eff_en;
  logic [CH_W-1:0] eff_chan;
  rec_t            rec;
  logic [WC_W-1:0] fin_cnt;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  cal_evt_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .last     (in_last),
    .cfg_en   (cfg_cal_en),
    .cfg_chan (cfg_chan),
    .eff_en   (eff_en),
    .eff_chan (eff_chan)
  );

  cal_rec_build #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rec (
    .pos   (in_pos),
    .ec_lo (in_ec_lo),
    .hits  (in_hits),
    .chan  (eff_chan),
    .rec   (rec)
  );

  cal_word_pack #(.WC_W(WC_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept && eff_en),
    .last      (in_last),
    .rec       (rec),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_last  (out_last),
    .fin_cnt   (fin_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_done <= 1'b0;
      evt_wcnt <= '0;
      hdr_evt  <= '0;
      hdr_chan <= '0;
    end else begin
      evt_done <= accept && in_last;
      if (accept && in_last) begin
        evt_wcnt <= eff_en ? fin_cnt : '0;
        hdr_evt  <= eff_en ? {PVER_CAL, PTYPE_CAL, 4'b0000} : '0;
        hdr_chan <= eff_en ? eff_chan : '0;
      end
    end
  end

  // R10: calibration summary arrives together with the final word
  assert_done_with_word_R10: assert property (@(posedge clk) disable iff (rst)
    (evt_done && hdr_evt[7:4] == PTYPE_CAL) |-> (out_valid && out_last));
  // R4: a calibration event always reports at least one word
  assert_wcnt_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (evt_done && hdr_evt[7:4] == PTYPE_CAL) |-> (evt_wcnt != '0));
  // R6: default-mode summary carries no words
  assert_default_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_done && hdr_evt == '0) |-> (evt_wcnt == '0 && hdr_chan == '0));
  // R9: input stalls while output is blocked
  assert_in_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/tb_calpack_top.sv
module tb_calpack_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_cal_en = 1'b0;
  logic [6:0]   cfg_chan = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_last = 1'b0;
  logic [4:0]   in_pos = '0;
  logic [1:0]   in_ec_lo = '0;
  logic [127:0] in_hits = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  out_word;
  logic         out_last;
  logic         evt_done;
  logic [9:0]   evt_wcnt;
  logic [10:0]  hdr_evt;
  logic [6:0]   hdr_chan;

  int nchk = 0;
  int nbad = 0;
  bit free_run = 1'b1;
  bit finished = 1'b0;

  logic [63:0] exp_w[$];
  bit          exp_l[$];
  int          exp_cnt[$];
  logic [10:0] exp_hdr[$];
  logic [6:0]  exp_ch[$];

  always #2 clk = ~clk;

  calpack_top dut (
    .clk(clk), .rst(rst), .cfg_cal_en(cfg_cal_en), .cfg_chan(cfg_chan),
    .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .in_pos(in_pos), .in_ec_lo(in_ec_lo), .in_hits(in_hits),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_last(out_last), .evt_done(evt_done), .evt_wcnt(evt_wcnt),
    .hdr_evt(hdr_evt), .hdr_chan(hdr_chan)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] mk_rec(logic [127:0] h, logic [6:0] ch,
                                        logic [1:0] ec, logic [4:0] p);
    return {h[ch], ec, p};
  endfunction

  // One event: expected words and summary are queued before driving it
  task automatic run_event(int n, bit en, logic [6:0] ch, bit scramble);
    logic [127:0] hv[32];
    logic [4:0]   pv[32];
    logic [1:0]   ev[32];
    logic [63:0]  w;
    w = '1;
    for (int i = 0; i < n; i++) begin
      hv[i] = {$urandom, $urandom, $urandom, $urandom};
      pv[i] = 5'($urandom % 31);
      ev[i] = 2'($urandom);
      if (en) begin
        w[63 - 8 * (i % 8) -: 8] = mk_rec(hv[i], ch, ev[i], pv[i]);
        if ((i % 8) == 7 || i == n - 1) begin
          exp_w.push_back(w);
          exp_l.push_back(i == n - 1);
          w = '1;
        end
      end
    end
    exp_cnt.push_back(en ? (n + 7) / 8 : 0);
    exp_hdr.push_back(en ? 11'h0F0 : 11'h000);
    exp_ch.push_back(en ? ch : 7'd0);
    cfg_cal_en = en;
    cfg_chan   = ch;
    for (int i = 0; i < n; i++) begin
      repeat ($urandom % 3) begin @(posedge clk); #1; end
      in_valid = 1'b1;
      in_last  = (i == n - 1);
      in_pos   = pv[i];
      in_ec_lo = ev[i];
      in_hits  = hv[i];
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
      // R8: change settings mid-event; the event must keep its own
      if (scramble && i == 0 && n > 1) begin
        cfg_cal_en = ~en;
        cfg_chan   = ch ^ 7'h55;
      end
    end
  endtask

  // Downstream backpressure
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = free_run ? 1'b1 : (($urandom % 4) != 0);
    end
  end

  // Monitor, sampling away from the active edge
  initial begin
    bit          was_stall;
    logic [63:0] stall_word;
    was_stall = 1'b0;
    stall_word = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (was_stall)
          chk(out_valid && out_word == stall_word, "R9 stall hold", out_word, stall_word);
        if (out_valid && !out_ready)
          chk(!in_ready, "R9 in_ready low", {63'd0, in_ready}, 64'd0);
        if (out_valid && out_ready) begin
          if (exp_w.size() == 0) begin
            chk(1'b0, "R6 unexpected word", out_word, 64'd0);
          end else begin
            logic [63:0] ew;
            bit          el;
            ew = exp_w.pop_front();
            el = exp_l.pop_front();
            chk(out_word == ew, "R1 R2 R3 word", out_word, ew);
            chk(out_last == el, "R10 last flag", {63'd0, out_last}, {63'd0, el});
          end
        end
        if (evt_done) begin
          if (exp_cnt.size() == 0) begin
            chk(1'b0, "R10 unexpected evt_done", 64'd1, 64'd0);
          end else begin
            int          ec;
            logic [10:0] eh;
            logic [6:0]  ech;
            ec  = exp_cnt.pop_front();
            eh  = exp_hdr.pop_front();
            ech = exp_ch.pop_front();
            chk(evt_wcnt == 10'(ec), "R4 word count", 64'(evt_wcnt), 64'(ec));
            chk(hdr_evt == eh, "R5 R6 header field", 64'(hdr_evt), 64'(eh));
            chk(hdr_chan == ech, "R7 channel field", 64'(hdr_chan), 64'(ech));
            if (eh != 0)
              chk(out_valid && out_last, "R10 done with final word",
                  {62'd0, out_valid, out_last}, 64'd3);
          end
        end
        was_stall  = out_valid && !out_ready;
        stall_word = out_word;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(!out_valid && !evt_done, "R11 reset valid/done", {62'd0, out_valid, evt_done}, 64'd0);
    chk(evt_wcnt == 0 && hdr_evt == 0 && hdr_chan == 0, "R11 reset summary",
        {28'd0, evt_wcnt, hdr_evt, hdr_chan}, 64'd0);
    chk(in_ready, "R11 reset in_ready", {63'd0, in_ready}, 64'd1);
    @(posedge clk); #1;
    // Directed corners
    run_event(1, 1'b1, 7'd0, 1'b0);    // R3 seven padded slots
    run_event(8, 1'b1, 7'd127, 1'b0);  // R3 no padding on exact fill
    run_event(9, 1'b1, 7'd64, 1'b0);   // R4 two words
    run_event(16, 1'b1, 7'd5, 1'b1);   // R8 scramble during cal event
    run_event(7, 1'b0, 7'd9, 1'b0);    // R6 default mode
    run_event(3, 1'b0, 7'd33, 1'b1);   // R8 scramble during default event
    run_event(2, 1'b1, 7'd17, 1'b0);   // R11 fresh word after previous event
    free_run = 1'b0;
    for (int e = 0; e < 40; e++)
      run_event(1 + int'($urandom % 24), ($urandom % 4) != 0, 7'($urandom), ($urandom % 2) == 1);
    free_run = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(exp_w.size() == 0, "R4 all words seen", 64'(exp_w.size()), 64'd0);
    chk(exp_cnt.size() == 0, "R10 all summaries seen", 64'(exp_cnt.size()), 64'd0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule